// File: doc/BRIEF.md
# Dual-Bank Flow-Through Burst Memory

This block is a synthesizable behavioural model of a two-bank synchronous burst static memory. Each stored word is 64 data bits plus eight parity bits, one for each data byte. The parity bits are stored and returned but never computed or checked. Address, bank enables, the global write line and write data are all captured on the rising clock edge. Reads are flow-through: the addressed word appears during the clock period that follows the capturing edge, with no output register stage in between.

An access begins on one of two start strobes. The processor strobe always begins a read. The controller strobe begins a read or a write, chosen by the global write line, and it also deselects the memory when no bank is enabled. With both strobes high, the advance input either steps a four-beat burst or holds the current address. A static order input selects linear or interleaved burst sequencing. An asynchronous output enable gates the read data. Each bank also has a sleep input that shuts it out of accesses.

Top module: `dual_bank_burst_sram`

## Requirements
- R1: While reset is asserted and after it is released, no burst is active: `rvalid` is 0 and `rdata`/`rpar` are 0.
- R2: On an edge where `ctl_strobe_n` is low and `bank_en_n` is 2'b11, the active burst ends. Outputs stay quiet (valid 0, data 0), and later advance cycles do nothing until a new start.
- R3: On an edge where `cpu_strobe_n` is low and at least one `bank_en_n` bit is low, a read burst begins at `addr` and `gwrite_n` is ignored. This holds even when `ctl_strobe_n` is low in the same cycle, and the word at `addr` is left unchanged.
- R4: On an edge where `cpu_strobe_n` is high, `ctl_strobe_n` is low and a bank is enabled, a write burst begins at `addr` if `gwrite_n` is low, and a read burst begins there if it is high.
- R5: On an edge with both strobes high during an active burst, `adv_n` low moves to the next burst address and `adv_n` high repeats the current one. On that edge `gwrite_n` low writes and `gwrite_n` high reads.
- R6: A burst walks four addresses in which only the two lowest address bits change. For step n = 0..3 from start low bits s, `burst_order`=0 gives (s+n) mod 4 and `burst_order`=1 gives s XOR n. After step 3 the sequence wraps back to step 0.
- R7: During a read, `rvalid`=1 and `{rpar,rdata}` hold the word at the current burst address in the period right after the edge that selected that address.
- R8: `oe_n` high forces `rvalid` to 0 and `rdata`/`rpar` to 0 without waiting for a clock edge. Lowering `oe_n` during a read shows the data at once.
- R9: While `sleep[b]` is 1, a start aimed at bank b acts as a deselect, writes to bank b are discarded, and bank b drives no read data.
- R10: `bank_en_n[0]` low selects bank 0 and has priority. `bank_en_n` = 2'b01 selects bank 1. The two banks store separate words at the same address.
- R11: A write stores all 72 bits, `wdata` together with `wpar` (bit i is the parity of byte i). A read returns both unchanged.
- R12: Write data is captured on the same edge as its address, and `rvalid` stays 0 during write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs captured on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of burst state |
| addr | input | AW | External word address within a bank |
| bank_en_n | input | 2 | Active-low bank enables, bit 0 for bank 0 |
| cpu_strobe_n | input | 1 | Active-low processor start strobe (always read) |
| ctl_strobe_n | input | 1 | Active-low controller start strobe (read, write or deselect) |
| adv_n | input | 1 | Active-low burst advance; high repeats the address |
| gwrite_n | input | 1 | Active-low global write of the full word |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 2 | Active-high per-bank sleep |
| burst_order | input | 1 | Static burst order: 0 linear, 1 interleaved |
| wdata | input | DW | Write data |
| wpar | input | DW/8 | Write parity, one bit for each data byte |
| rdata | output | DW | Read data, 0 when not valid |
| rpar | output | DW/8 | Read parity, 0 when not valid |
| rvalid | output | 1 | Read data is being driven |

## Verification
The bench builds the block with `AW`=3, which gives eight words per bank. This makes it cheap to write and read back every word of both banks. With that depth, every start position inside a four-word block and both burst orders can be swept, so each linear and interleaved sequence, including its wrap, is compared against a shadow memory kept in the bench. The small depth also leaves room for the strobe-priority, sleep, deselect and asynchronous output-enable cases against the same shadow contents.

// File: rtl/dbsram_pkg.sv
package dbsram_pkg;

  localparam int BANKS = 2;
  localparam int BEATS = 4;

  // Low two address bits of burst step 'step' from start bits 'base'.
  // order 0: linear wrap within four; order 1: interleaved (xor).
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] step,
                                           input logic       order);
    logic [1:0] res;
    if (order) res = base ^ step;
    else       res = base + step;
    return res;
  endfunction

endpackage

// File: rtl/burst_access_ctrl.sv
module burst_access_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bank_en_n,
  input  logic [1:0] sleep,
  input  logic       cpu_strobe_n,
  input  logic       ctl_strobe_n,
  input  logic       adv_n,
  input  logic       gwrite_n,
  output logic       start,
  output logic       advance,
  output logic       wr_fire,
  output logic       wr_bank,
  output logic       active,
  output logic       cur_bank,
  output logic       cur_write
);

  logic any_sel;
  logic sel_bank;
  logic p_start;
  logic c_start;
  logic begin_req;
  logic desel;
  logic cont;
  logic begin_write;

  // Cycle decode: processor strobe wins over controller strobe.
  always_comb begin
    any_sel     = (bank_en_n != 2'b11);
    sel_bank    = bank_en_n[0];          // 0 when enable 0 is low (priority)
    p_start     = !cpu_strobe_n && any_sel;
    c_start     = !ctl_strobe_n && any_sel && !p_start;
    begin_req   = p_start || c_start;
    desel       = !ctl_strobe_n && !any_sel;
    start       = begin_req && !sleep[sel_bank];
    begin_write = c_start && !gwrite_n;
    cont        = cpu_strobe_n && ctl_strobe_n && active;
    advance     = cont && !adv_n;
    wr_fire     = (start && begin_write) || (cont && !gwrite_n && !sleep[cur_bank]);
    wr_bank     = start ? sel_bank : cur_bank;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cur_bank  <= 1'b0;
      cur_write <= 1'b0;
    end else if (start) begin
      active    <= 1'b1;
      cur_bank  <= sel_bank;
      cur_write <= begin_write;
    end else if (desel || begin_req) begin
      active    <= 1'b0;             // deselect, or start on a sleeping bank
    end else if (cont) begin
      cur_write <= !gwrite_n;
    end
  end

  AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_strobe_n && cpu_strobe_n && (bank_en_n == 2'b11)) |=> !active) // R2
    else $error("deselect left burst active");

  AST_CPU_STROBE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_strobe_n && (bank_en_n != 2'b11) &&
     !(bank_en_n[0] ? sleep[1] : sleep[0])) |=> (active && !cur_write)) // R3
    else $error("processor strobe did not start a read");

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import dbsram_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          advance,
  input  logic          order,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] wr_addr
);

  localparam int HI = AW - 2;

  logic [AW-1:0] base;
  logic [1:0]    cnt;
  logic [1:0]    cnt_nx;

  assign cnt_nx   = cnt + 2'd1;
  assign cur_addr = {base[AW-1:2], burst_low(base[1:0], cnt, order)};

  // Address this edge acts on (used for early writes).
  always_comb begin
    if (start)        wr_addr = ext_addr;
    else if (advance) wr_addr = {base[AW-1:2], burst_low(base[1:0], cnt_nx, order)};
    else              wr_addr = cur_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
      cnt  <= '0;
    end else if (start) begin
      base <= ext_addr;
      cnt  <= '0;
    end else if (advance) begin
      cnt  <= cnt_nx;
    end
  end

  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !start) |=> (cnt == $past(cnt) + 2'd1)) // R5
    else $error("advance did not step the burst counter");

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !start) |=> ($stable(base) && $stable(cnt))) // R5
    else $error("burst address moved without advance");

  initial begin
    if (HI < 0) $error("AW must be at least 2");
  end

endmodule

// File: rtl/bank_store.sv
module bank_store #(
  parameter int AW = 4,
  parameter int WW = 72
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          sleep_i,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wword,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rword
);

  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wword;
  end

  assign rword = mem[raddr];

  AST_SLEEP_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !sleep_i) // R9
    else $error("write reached a sleeping bank");

endmodule

// File: rtl/dual_bank_burst_sram.sv
module dual_bank_burst_sram
  import dbsram_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic [1:0]      bank_en_n,
  input  logic            cpu_strobe_n,
  input  logic            ctl_strobe_n,
  input  logic            adv_n,
  input  logic            gwrite_n,
  input  logic            oe_n,
  input  logic [1:0]      sleep,
  input  logic            burst_order,
  input  logic [DW-1:0]   wdata,
  input  logic [DW/8-1:0] wpar,
  output logic [DW-1:0]   rdata,
  output logic [DW/8-1:0] rpar,
  output logic            rvalid
);

  localparam int PW = DW / 8;
  localparam int WW = DW + PW;

  logic          start;
  logic          advance;
  logic          wr_fire;
  logic          wr_bank;
  logic          active;
  logic          cur_bank;
  logic          cur_write;
  logic [AW-1:0] cur_addr;
  logic [AW-1:0] wr_addr;
  logic [WW-1:0] bank_rd [BANKS];
  logic [WW-1:0] sel_word;
  logic          rd_valid;

  burst_access_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .bank_en_n    (bank_en_n),
    .sleep        (sleep),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .adv_n        (adv_n),
    .gwrite_n     (gwrite_n),
    .start        (start),
    .advance      (advance),
    .wr_fire      (wr_fire),
    .wr_bank      (wr_bank),
    .active       (active),
    .cur_bank     (cur_bank),
    .cur_write    (cur_write)
  );

  burst_addr_gen #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .advance  (advance),
    .order    (burst_order),
    .ext_addr (addr),
    .cur_addr (cur_addr),
    .wr_addr  (wr_addr)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic we_b;
    assign we_b = wr_fire && (wr_bank == 1'(b));
    bank_store #(.AW(AW), .WW(WW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (we_b),
      .sleep_i (sleep[b]),
      .waddr   (wr_addr),
      .wword   ({wpar, wdata}),
      .raddr   (cur_addr),
      .rword   (bank_rd[b])
    );
  end

  // Flow-through read: no register between array and outputs.
  assign rd_valid = active && !cur_write && !oe_n && !sleep[cur_bank];
  assign sel_word = bank_rd[cur_bank];
  assign rvalid   = rd_valid;
  assign rdata    = rd_valid ? sel_word[DW-1:0]  : '0;
  assign rpar     = rd_valid ? sel_word[WW-1:DW] : '0;

endmodule

// File: tb/dual_bank_burst_sram_bench.sv
`timescale 1ns/1ps
module dual_bank_burst_sram_bench;

  localparam int AW = 3;
  localparam int DW = 64;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]    bank_en_n = 2'b11;
  logic          cpu_strobe_n = 1'b1;
  logic          ctl_strobe_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          gwrite_n = 1'b1;
  logic          oe_n = 1'b0;
  logic [1:0]    sleep = 2'b00;
  logic          burst_order = 1'b0;
  logic [63:0]   wdata = '0;
  logic [7:0]    wpar = '0;
  logic [63:0]   rdata;
  logic [7:0]    rpar;
  logic          rvalid;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [71:0] shadow [2][NW];

  always #2.5 clk = ~clk;

  dual_bank_burst_sram #(.AW(AW), .DW(DW)) u_dual_bank_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .bank_en_n(bank_en_n),
    .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n), .adv_n(adv_n),
    .gwrite_n(gwrite_n), .oe_n(oe_n), .sleep(sleep), .burst_order(burst_order),
    .wdata(wdata), .wpar(wpar), .rdata(rdata), .rpar(rpar), .rvalid(rvalid)
  );

  function automatic logic [71:0] pat(int b, int a, int s);
    logic [63:0] d;
    logic [7:0]  p;
    d = 64'h0123_4567_89AB_CDEF * 64'(a + 1) + 64'(b) * 64'h1111_0000_0000_1111
        + 64'(s) * 64'h0000_0101_0101_0000;
    p = 8'(a * 29 + b * 71 + s * 3 + 5);
    return {p, d};
  endfunction

  // Burst address restated arithmetically: block base plus offset.
  function automatic int ea(int a, int k, bit ord);
    int blk = a - (a % 4);
    int lo  = a % 4;
    return ord ? blk + (lo ^ k) : blk + ((lo + k) % 4);
  endfunction

  function automatic logic [1:0] en_of(int b);
    return (b == 0) ? 2'b10 : 2'b01;
  endfunction

  task automatic drive(bit p, bit c, bit adv, bit wr, logic [1:0] en, int a,
                       logic [71:0] w);
    cpu_strobe_n = p; ctl_strobe_n = c; adv_n = adv; gwrite_n = wr;
    bank_en_n = en; addr = AW'(a); {wpar, wdata} = w;
  endtask

  task automatic idle();
    drive(1, 1, 1, 1, 2'b11, 0, '0);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [72:0] exp);
    logic [72:0] act;
    act = {rvalid, rpar, rdata};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [72:0] rd(int b, int a);
    return {1'b1, shadow[b][a]};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) tick();
    chk("R1 in reset", 73'd0);
    rst_n = 1'b1;
    tick();
    chk("R1 after reset", 73'd0);

    // R4/R11/R12: single controller-strobe writes to every word of both banks
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < NW; a++) begin
        drive(1, 0, 1, 0, en_of(b), a, pat(b, a, 0));
        tick();
        shadow[b][a] = pat(b, a, 0);
        chk("R12 write cycle quiet", 73'd0);
      end
    idle(); tick();

    // R3/R7/R10/R11: processor-strobe reads, gwrite_n low ignored
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < NW; a++) begin
        drive(0, 1, 1, 0, en_of(b), a, pat(3, a, 9));
        tick();
        chk("R3 R7 R10 R11 read", rd(b, a));
      end

    // R10: both enables low selects bank 0
    drive(0, 1, 1, 1, 2'b00, 6, '0); tick();
    chk("R10 enable priority", rd(0, 6));

    // R4: controller-strobe read with gwrite_n high
    drive(1, 0, 1, 1, en_of(1), 3, '0); tick();
    chk("R4 controller read", rd(1, 3));

    // R3: both strobes low with gwrite_n low is a read, no write
    drive(0, 0, 1, 0, en_of(0), 2, pat(2, 2, 7)); tick();
    chk("R3 both strobes read", rd(0, 2));
    idle(); tick();
    drive(0, 1, 1, 1, en_of(0), 2, '0); tick();
    chk("R3 word unchanged", rd(0, 2));

    // R5/R6: write and read bursts for every start and both orders
    for (int o = 0; o < 2; o++)
      for (int a = 0; a < NW; a++) begin
        int b = o;
        int s = a + o * 8 + 1;
        burst_order = o[0];
        drive(1, 0, 1, 0, en_of(b), a, pat(b, ea(a, 0, o[0]), s)); tick();
        shadow[b][ea(a, 0, o[0])] = pat(b, ea(a, 0, o[0]), s);
        for (int k = 1; k < 4; k++) begin
          drive(1, 1, 0, 0, 2'b11, 0, pat(b, ea(a, k, o[0]), s)); tick();
          shadow[b][ea(a, k, o[0])] = pat(b, ea(a, k, o[0]), s);
          chk("R5 R12 burst write quiet", 73'd0);
        end
        drive(0, 1, 1, 1, en_of(b), a, '0); tick();
        chk("R6 burst beat 0", rd(b, ea(a, 0, o[0])));
        for (int k = 1; k < 4; k++) begin
          drive(1, 1, 0, 1, 2'b11, 0, '0); tick();
          chk("R6 burst beat", rd(b, ea(a, k, o[0])));
        end
        drive(1, 1, 1, 1, 2'b11, 0, '0); tick();
        chk("R5 hold repeats", rd(b, ea(a, 3, o[0])));
        drive(1, 1, 0, 1, 2'b11, 0, '0); tick();
        chk("R6 wrap", rd(b, ea(a, 0, o[0])));
      end
    burst_order = 1'b0;

    // R5: hold during a write burst rewrites the same address
    drive(1, 0, 1, 0, en_of(0), 5, pat(0, 5, 40)); tick();
    drive(1, 1, 1, 0, 2'b11, 0, pat(0, 5, 41)); tick();
    shadow[0][5] = pat(0, 5, 41);
    drive(0, 1, 1, 1, en_of(0), 5, '0); tick();
    chk("R5 write hold", rd(0, 5));

    // R8: output enable acts without a clock edge
    oe_n = 1'b1;
    drive(0, 1, 1, 1, en_of(1), 4, '0); tick();
    chk("R8 oe high quiet", 73'd0);
    oe_n = 1'b0; #1;
    chk("R8 oe low async", rd(1, 4));
    oe_n = 1'b1; #1;
    chk("R8 oe high async", 73'd0);
    oe_n = 1'b0;

    // R2: deselect ends the burst; advance afterwards does nothing
    drive(1, 0, 1, 1, 2'b11, 0, '0); tick();
    chk("R2 deselect", 73'd0);
    drive(1, 1, 0, 1, 2'b11, 0, '0); tick();
    chk("R2 no burst after deselect", 73'd0);

    // R9: sleeping bank ignores start and write, drives nothing
    sleep = 2'b10;
    drive(1, 0, 1, 0, en_of(1), 2, pat(1, 2, 77)); tick();
    chk("R9 write to sleeping bank", 73'd0);
    drive(0, 1, 1, 1, en_of(1), 2, '0); tick();
    chk("R9 read of sleeping bank", 73'd0);
    sleep = 2'b00;
    drive(0, 1, 1, 1, en_of(1), 2, '0); tick();
    chk("R9 sleeping write discarded", rd(1, 2));
    drive(0, 1, 1, 1, en_of(0), 1, '0); tick();
    sleep = 2'b01; #1;
    chk("R9 sleep silences read", 73'd0);
    sleep = 2'b00; #1;
    chk("R9 wake restores read", rd(0, 1));

    idle(); tick();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule